// File: doc/BRIEF.md
# Incrementing Burst Address-Phase Sequencer

This block is the address-phase engine of a bus master that moves data in incrementing bursts whose length is not known when the burst begins. Local logic asks for a burst by giving a start address, a transfer size and a direction. After that, it steers each beat with two levels: one says the data for the next beat is available, and the other says the burst has more beats to come. The block turns these levels into the transfer type, address, burst kind, size and direction that the bus samples. When local data lags, the block marks the cycle as a pause, and the pause keeps the burst open.

After every pause the block alone decides what comes next. It can resume the same burst with a sequential beat, or it can close the burst. Closing returns the bus to idle or starts a fresh burst at once. Slave wait states freeze the whole address phase. A one-cycle completion flag tells local logic when the burst's last data phase has finished. Arbitration, data buffering and error responses sit outside this block.

Top module: `ahb_incr_burst_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the transfer type is IDLE (2'b00), the burst kind is SINGLE (3'b000) and the completion flag is low.
- R2: From idle, with hready high at an edge where req_start and beat_rdy are both high, the next cycle drives NONSEQ (2'b10) at req_addr, with the requested size and direction. The burst kind is INCR (3'b001) whenever the transfer type is not IDLE.
- R3: When a NONSEQ or SEQ beat is accepted (hready high) with beat_more and beat_rdy high, the next cycle drives SEQ (2'b11) at the previous address plus 2^size bytes.
- R4: When a beat is accepted with beat_more high and beat_rdy low, the next cycle drives BUSY (2'b01) at the address of the next pending beat, and the burst stays open.
- R5: BUSY repeats while beat_rdy stays low and beat_more stays high. It is followed by SEQ at the same, unchanged address once beat_rdy rises. The address never advances on a BUSY cycle.
- R6: An accepted beat with beat_more low closes the burst. The next cycle is IDLE, or NONSEQ at a new req_addr if req_start and beat_rdy are high at that edge.
- R7: A BUSY cycle with hready high and beat_more low closes the burst, and the next cycle is IDLE.
- R8: While hready is low, the transfer type, address, size and direction hold their values, and every request input is ignored.
- R9: BUSY and SEQ never directly follow IDLE. From idle, req_start without beat_rdy starts no burst.
- R10: burst_done is high for exactly one cycle after the final beat's data phase completes with hready high. When a burst is closed from a BUSY cycle, it is high in the cycle after that BUSY cycle is accepted.
- R11: While a burst is open and beat_more is high, req_start has no effect on the transfer type or the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request to open a new burst |
| req_addr | input | ADDR_W | Start address of the requested burst |
| req_size | input | 3 | Transfer size code, bytes = 2^size |
| req_write | input | 1 | Direction of the requested burst, 1 = write |
| beat_rdy | input | 1 | Local data for the next beat is available |
| beat_more | input | 1 | The burst continues after the current point |
| hready | input | 1 | Bus ready; low stretches the current phase |
| htrans | output | 2 | Transfer type |
| haddr | output | ADDR_W | Transfer address |
| hburst | output | 3 | Burst kind |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| burst_done | output | 1 | One-cycle completion flag |

## Verification
The hardest case to reach is a stack of conditions: a pause that repeats, is then stretched by a wait state, and finally resumes or closes the burst. The completion flag then has to come from the BUSY path and not from a beat. Each of these requires beat_rdy, beat_more and hready to take particular values in consecutive cycles. The stimulus table therefore scripts these three levels cycle by cycle, and it includes back-to-back single-beat bursts, so that completion flags from two bursts fall in adjacent cycles.

// File: rtl/ahb_seq_pkg.sv
package ahb_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;

endpackage

// File: rtl/ahb_seq_ctrl.sv
module ahb_seq_ctrl
  import ahb_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hready,
  input  logic   req_start,
  input  logic   beat_rdy,
  input  logic   beat_more,
  output trans_e trans_q,
  output logic   load,
  output logic   step,
  output logic   last_acc,
  output logic   end_busy
);

  trans_e trans_d;
  logic   is_beat;
  logic   can_start;

  assign is_beat   = (trans_q == TR_NONSEQ) || (trans_q == TR_SEQ);
  assign can_start = req_start & beat_rdy;

  always_comb begin
    trans_d  = trans_q;
    load     = 1'b0;
    step     = 1'b0;
    last_acc = 1'b0;
    end_busy = 1'b0;
    if (hready) begin
      if (trans_q == TR_IDLE) begin
        if (can_start) begin
          trans_d = TR_NONSEQ;
          load    = 1'b1;
        end
      end else if (beat_more) begin
        // burst stays open: advance address only after a real beat
        trans_d = beat_rdy ? TR_SEQ : TR_BUSY;
        step    = is_beat;
      end else begin
        last_acc = is_beat;
        end_busy = (trans_q == TR_BUSY);
        if (can_start) begin
          trans_d = TR_NONSEQ;
          load    = 1'b1;
        end else begin
          trans_d = TR_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
    end else if (hready) begin
      trans_q <= trans_d;
    end
  end

endmodule

// File: rtl/ahb_seq_addr.sv
module ahb_seq_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  output logic [ADDR_W-1:0] addr_q,
  output logic [2:0]        size_q,
  output logic              write_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        size_d;
  logic              write_d;
  logic              en;

  assign en = load | step;

  always_comb begin
    addr_d  = addr_q;
    size_d  = size_q;
    write_d = write_q;
    if (load) begin
      addr_d  = req_addr;
      size_d  = req_size;
      write_d = req_write;
    end else if (step) begin
      addr_d = addr_q + (ONE << size_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
    end else if (en) begin
      addr_q  <= addr_d;
      size_q  <= size_d;
      write_q <= write_d;
    end
  end

endmodule

// File: rtl/ahb_seq_done.sv
module ahb_seq_done (
  input  logic clk,
  input  logic rst_n,
  input  logic hready,
  input  logic last_acc,
  input  logic end_busy,
  output logic done_q
);

  logic tail_q;
  logic tail_d;
  logic done_d;

  always_comb begin
    tail_d = tail_q;
    if (hready) begin
      tail_d = last_acc;
    end
    done_d = hready & (tail_q | end_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      tail_q <= tail_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/ahb_incr_burst_seq.sv
module ahb_incr_burst_seq
  import ahb_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  input  logic              beat_rdy,
  input  logic              beat_more,
  input  logic              hready,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              hwrite,
  output logic              burst_done
);

  trans_e trans;
  logic   load;
  logic   step;
  logic   last_acc;
  logic   end_busy;

  ahb_seq_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .req_start (req_start),
    .beat_rdy  (beat_rdy),
    .beat_more (beat_more),
    .trans_q   (trans),
    .load      (load),
    .step      (step),
    .last_acc  (last_acc),
    .end_busy  (end_busy)
  );

  ahb_seq_addr #(.ADDR_W(ADDR_W)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .addr_q    (haddr),
    .size_q    (hsize),
    .write_q   (hwrite)
  );

  ahb_seq_done i_done (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .last_acc (last_acc),
    .end_busy (end_busy),
    .done_q   (burst_done)
  );

  assign htrans = trans;
  assign hburst = (trans == TR_IDLE) ? BURST_SINGLE : BURST_INCR;

endmodule

// File: rtl/ahb_incr_burst_seq_chk.sv
module ahb_incr_burst_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_start,
  input logic              beat_rdy,
  input logic              beat_more,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic [ADDR_W-1:0] haddr,
  input logic [2:0]        hsize,
  input logic              hwrite,
  input logic              burst_done
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R8
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(htrans) && $stable(haddr) && $stable(hsize) && $stable(hwrite)));

  // R9
  no_pause_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b00) |=> (htrans != 2'b01 && htrans != 2'b11));

  // R3
  seq_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hready && beat_more) |=> (haddr == $past(haddr) + (ONE << $past(hsize))));

  // R5
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b01 && hready && beat_more) |=> $stable(haddr));

  // R11
  open_burst_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && hready && beat_more) |=> (htrans == 2'b11 || htrans == 2'b01));

  // R7
  busy_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b01 && hready && !beat_more && !(req_start && beat_rdy)) |=> (htrans == 2'b00 && burst_done));

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(hready));

endmodule

bind ahb_incr_burst_seq ahb_incr_burst_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_start  (req_start),
  .beat_rdy   (beat_rdy),
  .beat_more  (beat_more),
  .hready     (hready),
  .htrans     (htrans),
  .haddr      (haddr),
  .hsize      (hsize),
  .hwrite     (hwrite),
  .burst_done (burst_done)
);

// File: tb/test_ahb_incr_burst_seq.sv
module test_ahb_incr_burst_seq;

  typedef struct packed {
    logic        st;
    logic        rdy;
    logic        more;
    logic        hr;
    logic [31:0] addr;
    logic [2:0]  size;
    logic        wr;
    logic [1:0]  etr;
    logic [31:0] ead;
    logic        edone;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd9},  // R9 idle stays idle
    '{1'b1,1'b0,1'b1,1'b1,32'h1000,3'd2,1'b1,2'b00,32'h0,   1'b0,4'd9},  // R9 start without data
    '{1'b1,1'b1,1'b1,1'b1,32'h1000,3'd2,1'b1,2'b10,32'h1000,1'b0,4'd2},  // R2 first beat
    '{1'b0,1'b1,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b11,32'h1004,1'b0,4'd3},  // R3 seq step
    '{1'b0,1'b0,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b01,32'h1008,1'b0,4'd4},  // R4 pause
    '{1'b0,1'b0,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b01,32'h1008,1'b0,4'd5},  // R5 pause repeats
    '{1'b0,1'b1,1'b1,1'b0,32'h0,   3'd0,1'b0,2'b01,32'h1008,1'b0,4'd8},  // R8 wait holds pause
    '{1'b0,1'b1,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b11,32'h1008,1'b0,4'd5},  // R5 resume
    '{1'b0,1'b1,1'b1,1'b0,32'h0,   3'd0,1'b0,2'b11,32'h1008,1'b0,4'd8},  // R8 wait holds beat
    '{1'b1,1'b1,1'b1,1'b1,32'h5000,3'd0,1'b0,2'b11,32'h100C,1'b0,4'd11}, // R11 start ignored
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd6},  // R6 close after beat
    '{1'b0,1'b1,1'b0,1'b0,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd10}, // R10 data phase waits
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b1,4'd10}, // R10 done
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd10}, // R10 single cycle
    '{1'b1,1'b1,1'b1,1'b1,32'h2003,3'd0,1'b0,2'b10,32'h2003,1'b0,4'd2},  // R2 byte burst
    '{1'b0,1'b0,1'b1,1'b1,32'h0,   3'd0,1'b0,2'b01,32'h2004,1'b0,4'd4},  // R4 pause
    '{1'b0,1'b0,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b1,4'd7},  // R7 close from pause
    '{1'b0,1'b0,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd7},  // R7 quiet after
    '{1'b1,1'b1,1'b1,1'b1,32'h3000,3'd1,1'b1,2'b10,32'h3000,1'b0,4'd2},  // R2 halfword burst
    '{1'b1,1'b1,1'b0,1'b1,32'h4000,3'd1,1'b1,2'b10,32'h4000,1'b0,4'd6},  // R6 back-to-back
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b1,4'd10}, // R10 first done
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b1,4'd10}, // R10 second done
    '{1'b0,1'b1,1'b0,1'b1,32'h0,   3'd0,1'b0,2'b00,32'h0,   1'b0,4'd10}, // R10 cleared
    '{1'b1,1'b1,1'b1,1'b0,32'h6000,3'd2,1'b0,2'b00,32'h0,   1'b0,4'd8}   // R8 start held off
  };

  logic        clk;
  logic        rst_n;
  logic        req_start;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic        req_write;
  logic        beat_rdy;
  logic        beat_more;
  logic        hready;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic [2:0]  hburst;
  logic [2:0]  hsize;
  logic        hwrite;
  logic        burst_done;

  int checks;
  int fails;
  logic [2:0] cur_size;
  logic       cur_wr;

  ahb_incr_burst_seq #(.ADDR_W(32)) i_ahb_incr_burst_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .beat_rdy   (beat_rdy),
    .beat_more  (beat_more),
    .hready     (hready),
    .htrans     (htrans),
    .haddr      (haddr),
    .hburst     (hburst),
    .hsize      (hsize),
    .hwrite     (hwrite),
    .burst_done (burst_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R0 watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    checks = 0; fails = 0;
    cur_size = '0; cur_wr = 1'b0;
    rst_n = 1'b0; req_start = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; beat_rdy = 1'b0; beat_more = 1'b0; hready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk(1, "htrans in reset", 32'(htrans), 32'h0);
    chk(1, "hburst in reset", 32'(hburst), 32'h0);
    chk(1, "done in reset", 32'(burst_done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    chk(1, "htrans after release", 32'(htrans), 32'h0);

    for (int i = 0; i < NV; i++) begin
      req_start = VEC[i].st;
      beat_rdy  = VEC[i].rdy;
      beat_more = VEC[i].more;
      hready    = VEC[i].hr;
      req_addr  = VEC[i].addr;
      req_size  = VEC[i].size;
      req_write = VEC[i].wr;
      @(posedge clk);
      #2;
      if (VEC[i].st && VEC[i].etr == 2'b10) begin
        cur_size = VEC[i].size;
        cur_wr   = VEC[i].wr;
      end
      chk(VEC[i].req, $sformatf("vec %0d htrans", i), 32'(htrans), 32'(VEC[i].etr));
      chk(VEC[i].req, $sformatf("vec %0d done", i), 32'(burst_done), 32'(VEC[i].edone));
      // R2 burst kind follows transfer type
      chk(VEC[i].req, $sformatf("vec %0d hburst", i), 32'(hburst),
          (VEC[i].etr == 2'b00) ? 32'h0 : 32'h1);
      if (VEC[i].etr != 2'b00) begin
        chk(VEC[i].req, $sformatf("vec %0d haddr", i), haddr, VEC[i].ead);
        chk(VEC[i].req, $sformatf("vec %0d hsize", i), 32'(hsize), 32'(cur_size));
        chk(VEC[i].req, $sformatf("vec %0d hwrite", i), 32'(hwrite), 32'(cur_wr));
      end
      @(negedge clk);
    end

    // R1 reset in the middle of an open burst
    req_start = 1'b1; beat_rdy = 1'b1; beat_more = 1'b1; hready = 1'b1;
    req_addr = 32'h7000; req_size = 3'd2; req_write = 1'b1;
    @(negedge clk);
    req_start = 1'b0; beat_rdy = 1'b0;
    @(negedge clk);
    chk(4, "pause before reset", 32'(htrans), 32'h1);
    rst_n = 1'b0;
    #1;
    chk(1, "htrans async reset", 32'(htrans), 32'h0);
    chk(1, "hburst async reset", 32'(hburst), 32'h0);
    chk(1, "done async reset", 32'(burst_done), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    beat_more = 1'b0;
    @(negedge clk);
    chk(9, "idle after reset release", 32'(htrans), 32'h0);

    finish_run();
  end

endmodule